// File: doc/BRIEF.md
# Two-stage CIC audio decimator

This block brings one channel of complex baseband down from the converter sample rate to the audio transport rate. A quadrature mixer upstream delivers 22-bit I and Q products with a sample strobe. Two cascaded integrator-comb filters reduce the rate: a three-stage section decimating by 256, then a five-stage section decimating by 31. The block presents one 24-bit I/Q pair per 7936 accepted input samples. At a 65 MHz input rate this is about 8.2 kHz.

Each filter keeps its integrators at the sample rate of its input. It picks every R-th integrator result and runs its differentiators only on those picked samples. It then keeps only the upper bits of the differentiator result. No droop-compensation filter follows. Passband shaping, gain control and demodulation are left to downstream software.

Top module: `cic_audio_decim`

## Requirements
- R1: `in_i` and `in_q` are 22-bit two's-complement samples taken only on clock edges where `in_valid` is 1. Cycles with `in_valid` at 0 change neither the filter state nor any later output.
- R2: The first section has three integrators, each 46 bits wide. Each integrator adds the previous-cycle value of the one before it. The first section picks one value for every 256 accepted samples; that value is the last integrator's contents before the triggering sample is added. It passes bits 45:28 of its differentiator output on, so a long constant input x gives floor(x/16).
- R3: The second section has five integrators and five differentiators, each 48 bits wide, and decimates by 31. The output ports carry bits 47:24 of its last differentiator, so a long constant section input y gives floor(y·31^5/2^24).
- R4: `out_valid` is a one-cycle pulse, and exactly one pulse occurs for every 7936 accepted input samples.
- R5: Integrators wrap in two's complement without saturating. Full-scale constant input held for many output periods still gives the exact steady-state output.
- R6: Every differentiator subtracts the previous decimated sample it received (differential delay 1), and runs only when a decimated sample arrives.
- R7: Width reduction discards the low bits without rounding, so negative results round toward minus infinity.
- R8: The I and Q lanes are filtered independently with identical arithmetic, and they share one decimation phase and one strobe.
- R9: A synchronous active-low `rst_n` clears every integrator, differentiator, counter and strobe. While it is held, `out_valid`, `out_i` and `out_q` read 0. The first output after release equals that of a freshly cleared filter.
- R10: `out_valid` rises 9 clock cycles after the edge that accepts the 7936th sample of a group, whatever gaps occur in `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 22 | In-phase mixer product, two's complement |
| in_q | input | 22 | Quadrature mixer product, two's complement |
| out_valid | output | 1 | One-cycle strobe per audio sample |
| out_i | output | 24 | In-phase audio sample |
| out_q | output | 24 | Quadrature audio sample |

## Verification
The bench drives full-scale positive and negative constants for long enough that every integrator wraps many times. A saturating or under-sized accumulator would then settle on the wrong steady value. One negative level was picked so that rounding and truncation give different results; a design that rounded would be off by one LSB. A stretch of input with idle cycles between samples exposes a counter that advances on idle cycles, since its strobes would come early and its values would differ from the model. A reset in the middle of a group catches any partial sum that survives reset, because it would corrupt the first output after release.

// File: rtl/cic_pkg.sv
// Shared constants and sizing helpers for the CIC decimation chain.
// Assumes decimation ratios of at least 2.
package cic_pkg;

    // Number of parallel lanes (in-phase and quadrature).
    localparam int LANES = 2;

    // Register width for full bit growth of an integrator chain.
    function automatic int growth_width(input int in_w, input int stages, input int ratio);
        return in_w + stages * $clog2(ratio);
    endfunction

endpackage

// File: rtl/cic_integrator_chain.sv
// Pipelined chain of N integrators, advancing only when en is high.
// Stage k adds the registered value of stage k-1, so every stage is a
// single adder deep. Arithmetic wraps in two's complement.
module cic_integrator_chain #(
    parameter int W = 46,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);

    for (genvar k = 0; k < N; k++) begin : g_stage
        logic signed [W-1:0] acc;
        logic signed [W-1:0] feed;

        if (k == 0) begin : g_head
            assign feed = din;
        end else begin : g_tail
            assign feed = g_stage[k-1].acc;
        end

        // Accumulate the feed on every accepted sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc <= '0;
            end else if (en) begin
                acc <= acc + feed;
            end
        end
    end

    assign dout = g_stage[N-1].acc;

    // Without an accepted sample the chain output must hold.
    p_integ_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout));

endmodule

// File: rtl/cic_comb_chain.sv
// Chain of N differentiators with differential delay 1. A sample walks
// one stage per clock, carried by its own valid bit, and each stage
// updates only when a sample reaches it.
module cic_comb_chain #(
    parameter int W = 46,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] din,
    output logic                out_valid,
    output logic signed [W-1:0] dout
);

    for (genvar k = 0; k < N; k++) begin : g_stage
        logic                vld;
        logic signed [W-1:0] diff;
        logic signed [W-1:0] dly;
        logic signed [W-1:0] feed;
        logic                feed_v;

        if (k == 0) begin : g_head
            assign feed   = din;
            assign feed_v = in_valid;
        end else begin : g_tail
            assign feed   = g_stage[k-1].diff;
            assign feed_v = g_stage[k-1].vld;
        end

        // Subtract the previously received sample and remember the new one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld  <= 1'b0;
                diff <= '0;
                dly  <= '0;
            end else begin
                vld <= feed_v;
                if (feed_v) begin
                    diff <= feed - dly;
                    dly  <= feed;
                end
            end
        end

        if (k > 0) begin : g_walk
            // A sample leaving stage k-1 must appear at stage k one clock later.
            p_valid_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
                g_stage[k-1].vld |=> g_stage[k].vld);
        end
    end

    assign out_valid = g_stage[N-1].vld;
    assign dout      = g_stage[N-1].diff;

endmodule

// File: rtl/cic_stage.sv
// One CIC decimator section for an I/Q pair. It sign-extends the inputs,
// integrates at the input rate and picks one integrator value every R
// accepted samples (the value before the triggering sample is added).
// It then differentiates at the picked rate and keeps the upper OUT_W
// bits. Assumes R >= 2 and ACC_W >= IN_W + N*clog2(R).
module cic_stage
    import cic_pkg::*;
#(
    parameter int IN_W  = 22,
    parameter int N     = 3,
    parameter int R     = 256,
    parameter int ACC_W = 46,
    parameter int OUT_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);

    localparam int                CNT_W = $clog2(R);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(R - 1);
    localparam int                CUT_W = ACC_W - OUT_W;

    logic [CNT_W-1:0]                phase;
    logic                            pick;
    logic                            dec_valid;
    logic [LANES-1:0]                lane_vld;
    logic [LANES-1:0][OUT_W-1:0]     lane_out;

    assign pick = in_valid && (phase == LAST);

    // Count accepted samples modulo R.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (in_valid) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    // Mark the cycle after a pick as carrying a decimated sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= pick;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [IN_W-1:0]  src;
        logic signed [ACC_W-1:0] src_ext;
        logic signed [ACC_W-1:0] integ;
        logic signed [ACC_W-1:0] dec_q;
        logic signed [ACC_W-1:0] comb;
        logic [CUT_W-1:0]        trunc_unused;

        if (l == 0) begin : g_i
            assign src = in_i;
        end else begin : g_q
            assign src = in_q;
        end

        assign src_ext = {{(ACC_W - IN_W){src[IN_W-1]}}, src};

        cic_integrator_chain #(.W(ACC_W), .N(N)) u_integ (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (in_valid),
            .din  (src_ext),
            .dout (integ)
        );

        // Hold the picked integrator value for the differentiator chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dec_q <= '0;
            end else if (pick) begin
                dec_q <= integ;
            end
        end

        cic_comb_chain #(.W(ACC_W), .N(N)) u_comb (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (dec_valid),
            .din      (dec_q),
            .out_valid(lane_vld[l]),
            .dout     (comb)
        );

        assign lane_out[l]  = comb[ACC_W-1 -: OUT_W];
        assign trunc_unused = comb[CUT_W-1:0];
    end

    assign out_valid = lane_vld[0];
    assign out_i     = lane_out[0];
    assign out_q     = lane_out[1];

    // The section emits isolated one-cycle strobes.
    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // Both lanes deliver their results on the same cycle.
    p_lanes_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld[0] |-> lane_vld[1]);

endmodule

// File: rtl/cic_audio_decim.sv
// Two cascaded CIC sections taking a mixer's I/Q products to the
// audio transport rate. The first section's truncated result feeds the
// second section directly. Assumes the first section's strobes are at
// least S2_STAGES+1 cycles apart, which holds for S1_RATIO > S2_STAGES.
module cic_audio_decim
    import cic_pkg::*;
#(
    parameter int IN_W      = 22,
    parameter int S1_STAGES = 3,
    parameter int S1_RATIO  = 256,
    parameter int S1_OUT_W  = 18,
    parameter int S2_STAGES = 5,
    parameter int S2_RATIO  = 31,
    parameter int S2_ACC_W  = 48,
    parameter int S2_OUT_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [IN_W-1:0]     in_i,
    input  logic [IN_W-1:0]     in_q,
    output logic                out_valid,
    output logic [S2_OUT_W-1:0] out_i,
    output logic [S2_OUT_W-1:0] out_q
);

    localparam int S1_ACC_W = growth_width(IN_W, S1_STAGES, S1_RATIO);

    logic                       mid_valid;
    logic signed [S1_OUT_W-1:0] mid_i;
    logic signed [S1_OUT_W-1:0] mid_q;

    cic_stage #(
        .IN_W (IN_W),
        .N    (S1_STAGES),
        .R    (S1_RATIO),
        .ACC_W(S1_ACC_W),
        .OUT_W(S1_OUT_W)
    ) u_first (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .out_valid(mid_valid),
        .out_i    (mid_i),
        .out_q    (mid_q)
    );

    cic_stage #(
        .IN_W (S1_OUT_W),
        .N    (S2_STAGES),
        .R    (S2_RATIO),
        .ACC_W(S2_ACC_W),
        .OUT_W(S2_OUT_W)
    ) u_second (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (mid_valid),
        .in_i     (mid_i),
        .in_q     (mid_q),
        .out_valid(out_valid),
        .out_i    (out_i),
        .out_q    (out_q)
    );

    // Every audio strobe traces back to a first-section strobe a fixed time earlier.
    p_latency_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(mid_valid, S2_STAGES + 1));

endmodule

// File: tb/cic_audio_decim_bench.sv
// Self-checking bench: a behavioural reference model with integer
// arithmetic predicts every audio sample; outputs are compared at each
// falling edge.
module cic_audio_decim_bench;

    localparam int  IW = 22;
    localparam int  N1 = 3;
    localparam int  R1 = 256;
    localparam int  A1 = 46;
    localparam int  O1 = 18;
    localparam int  N2 = 5;
    localparam int  R2 = 31;
    localparam int  A2 = 48;
    localparam int  O2 = 24;
    localparam int  GROUP = R1 * R2;
    localparam int  LAT = N1 + N2 + 1;
    localparam int  WATCHDOG = 199000;
    localparam longint XPOS = 2097151;
    localparam longint XNEG = -2097147;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_i = '0;
    logic [IW-1:0] in_q = '0;
    logic          out_valid;
    logic [O2-1:0] out_i;
    logic [O2-1:0] out_q;

    int checks = 0;
    int fails = 0;
    int strobes = 0;
    longint cyc = 0;
    bit done = 1'b0;

    longint i1 [2][N1];
    longint d1 [2][N1];
    longint i2 [2][N2];
    longint d2 [2][N2];
    int c1 = 0;
    int c2 = 0;
    longint exp_i [$];
    longint exp_q [$];
    longint exp_edge [$];
    longint hist_i [$];
    longint hist_q [$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    cic_audio_decim u_cic_audio_decim (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .out_valid(out_valid),
        .out_i    (out_i),
        .out_q    (out_q)
    );

    function automatic longint wrapw(input longint v, input int w);
        int sh = 64 - w;
        return (v <<< sh) >>> sh;
    endfunction

    function automatic longint ss1(input longint x);
        return (x * (longint'(R1) ** N1)) >>> (A1 - O1);
    endfunction

    function automatic longint ss2(input longint y);
        return (y * (longint'(R2) ** N2)) >>> (A2 - O2);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int l = 0; l < 2; l++) begin
            for (int k = 0; k < N1; k++) begin i1[l][k] = 0; d1[l][k] = 0; end
            for (int k = 0; k < N2; k++) begin i2[l][k] = 0; d2[l][k] = 0; end
        end
        c1 = 0;
        c2 = 0;
        exp_i.delete();
        exp_q.delete();
        exp_edge.delete();
    endtask

    // Advance the reference by one accepted input pair.
    task automatic model_step(input longint xi, input longint xq);
        longint x [2];
        longint y [2];
        longint o [2];
        longint cap, v, t;
        bit e1, e2;
        x[0] = xi;
        x[1] = xq;
        e1 = (c1 == R1 - 1);
        e2 = 1'b0;
        for (int l = 0; l < 2; l++) begin
            cap = i1[l][N1-1];
            for (int k = N1 - 1; k > 0; k--) i1[l][k] = wrapw(i1[l][k] + i1[l][k-1], A1);
            i1[l][0] = wrapw(i1[l][0] + x[l], A1);
            y[l] = 0;
            if (e1) begin
                v = cap;
                for (int k = 0; k < N1; k++) begin
                    t = wrapw(v - d1[l][k], A1);
                    d1[l][k] = v;
                    v = t;
                end
                y[l] = wrapw(v >>> (A1 - O1), O1);
            end
        end
        c1 = e1 ? 0 : c1 + 1;
        if (e1) begin
            e2 = (c2 == R2 - 1);
            for (int l = 0; l < 2; l++) begin
                cap = i2[l][N2-1];
                for (int k = N2 - 1; k > 0; k--) i2[l][k] = wrapw(i2[l][k] + i2[l][k-1], A2);
                i2[l][0] = wrapw(i2[l][0] + y[l], A2);
                o[l] = 0;
                if (e2) begin
                    v = cap;
                    for (int k = 0; k < N2; k++) begin
                        t = wrapw(v - d2[l][k], A2);
                        d2[l][k] = v;
                        v = t;
                    end
                    o[l] = wrapw(v >>> (A2 - O2), O2);
                end
            end
            c2 = e2 ? 0 : c2 + 1;
            if (e2) begin
                exp_i.push_back(o[0]);
                exp_q.push_back(o[1]);
                exp_edge.push_back(cyc + 1);
            end
        end
    endtask

    task automatic send(input longint xi, input longint xq);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = xi[IW-1:0];
        in_q = xq[IW-1:0];
        model_step(xi, xq);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_i = '0;
            in_q = '0;
        end
    endtask

    // Compare every strobe against the model: values (R1, R6, R8) and timing (R10).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            strobes++;
            hist_i.push_back(longint'($signed(out_i)));
            hist_q.push_back(longint'($signed(out_q)));
            if (exp_i.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R4 unexpected strobe: actual 1 expected 0");
            end else begin
                chk("R1 R6 model I", longint'($signed(out_i)), exp_i.pop_front());
                chk("R8 model Q", longint'($signed(out_q)), exp_q.pop_front());
                chk("R10 latency", cyc - exp_edge.pop_front(), LAT);
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog: actual %0d cycles expected below %0d", WATCHDOG, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs quiet under reset
        chk("R9 reset out_valid", longint'(out_valid), 0);
        chk("R9 reset out_i", longint'(out_i), 0);
        chk("R9 reset out_q", longint'(out_q), 0);
        rst_n = 1'b1;

        // Phase A: full-scale constants, I positive and Q negative (R5, R7, R8).
        base = strobes;
        for (int k = 0; k < 8 * GROUP; k++) send(XPOS, XNEG);
        idle(20);
        chk("R4 strobes in phase A", strobes - base, 8);
        for (int j = 6; j < 8; j++) begin
            chk("R2 R3 steady I", hist_i[j], ss2(ss1(XPOS)));
            chk("R7 floor steady Q", hist_q[j], ss2(ss1(XNEG)));
        end

        // Phase B: swapped levels after wrap-around of every integrator (R5).
        base = strobes;
        for (int k = 0; k < 7 * GROUP; k++) send(XNEG, XPOS);
        idle(20);
        chk("R4 strobes in phase B", strobes - base, 7);
        for (int j = base + 5; j < base + 7; j++) begin
            chk("R5 R7 steady I after wrap", hist_i[j], ss2(ss1(XNEG)));
            chk("R5 steady Q after wrap", hist_q[j], ss2(ss1(XPOS)));
        end

        // Phase C: varying data with an idle cycle after every two samples (R1, R10).
        base = strobes;
        for (int k = 0; k < 2 * GROUP; k++) begin
            send(((longint'(k) * 1237) % 4194304) - 2097152,
                 (k % 2 == 1) ? 2097151 : -2097152);
            if (k % 2 == 1) idle(1);
        end
        idle(20);
        chk("R1 R4 strobes with gaps", strobes - base, 2);

        // Phase D: reset in the middle of a group (R9).
        for (int k = 0; k < 3000; k++) send(((longint'(k) * 131) % 4000000) - 2000000, 7777 - k);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid reset out_valid", longint'(out_valid), 0);
        chk("R9 mid reset out_i", longint'(out_i), 0);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
        base = strobes;
        for (int k = 0; k < GROUP; k++) send(-1234567, 765432);
        idle(20);
        chk("R9 R4 one strobe after reset", strobes - base, 1);
        chk("R4 no pending outputs", exp_i.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule